// File: doc/BRIEF.md
# Conversion Sample FIFO

This block holds the results of an analog-to-digital converter until software or a DMA engine reads them. After every conversion the converter offers a 12-bit value and an error flag. When the FIFO is enabled, the block formats that pair into a 16-bit entry and stores it. An entry can be packed so the value fits in one byte. The entry can also carry the error flag at a fixed bit.

The block reports how many entries are waiting. It raises a DMA request and an interrupt once that count reaches a programmable threshold. It keeps sticky flags for samples that were lost to a full FIFO and for reads made while the FIFO was empty. The interrupt output combines the raw condition with an enable bit and a force bit. A register interface outside this block drives the control inputs and forwards reads of the data port as pop strobes.

Top module: `sample_fifo`

## Requirements
- R1: After reset, the outputs hold these values: level_o = 0, empty_o = 1, full_o = 0, over_o = 0, under_o = 0 and rd_data_o = 0.
- R2: An entry is stored at a clock edge only when both push_i and fifo_en_i are 1. Entries leave in the order they were stored. level_o gives the number of stored entries, from 0 to 4. full_o is 1 at level 4 and empty_o is 1 at level 0.
- R3: The entry format is as follows:
  - Bits 11:0 hold the value when shift_en_i is 0.
  - When shift_en_i is 1, bits 7:0 hold value bits 11:4 and bits 11:8 are 0.
  - Bit 15 holds the error flag when err_keep_i is 1 and is 0 otherwise.
  - Bits 14:12 are always 0.
  - shift_en_i and err_keep_i are sampled when the entry is stored.
- R4: rd_data_o shows the oldest entry while the FIFO is not empty, and shows 0 while it is empty. pop_i removes that entry at the clock edge.
- R5: A push and a pop in the same cycle on a FIFO that is neither empty nor full leave level_o unchanged.
- R6: A push while full_o is 1 is dropped and sets over_o. This holds even when a pop happens in the same cycle: the pop still removes the oldest entry.
- R7: A pop while empty_o is 1 changes no entry and sets under_o. A push in the same cycle is still stored.
- R8: over_o stays set until a clock edge at which clr_over_i is 1. under_o behaves the same way with clr_under_i. If a new event and a clear arrive in the same cycle, the flag stays set.
- R9: dma_req_o is 1 exactly when req_en_i is 1 and level_o >= thresh_i.
- R10: irq_raw_o is 1 exactly when level_o >= thresh_i. irq_o equals (irq_raw_o AND irq_en_i) OR irq_force_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Conversion done strobe |
| push_val_i | input | 12 | Conversion value |
| push_err_i | input | 1 | Conversion error flag |
| pop_i | input | 1 | Data port read strobe |
| fifo_en_i | input | 1 | Store results when 1 |
| shift_en_i | input | 1 | Pack value into one byte |
| err_keep_i | input | 1 | Keep error flag in bit 15 |
| req_en_i | input | 1 | DMA request enable |
| thresh_i | input | 4 | Request and interrupt threshold |
| clr_over_i | input | 1 | Clear overflow flag |
| clr_under_i | input | 1 | Clear underflow flag |
| irq_en_i | input | 1 | Interrupt enable |
| irq_force_i | input | 1 | Interrupt force |
| rd_data_o | output | 16 | Oldest entry, or 0 when empty |
| level_o | output | 4 | Entries waiting |
| full_o | output | 1 | FIFO full |
| empty_o | output | 1 | FIFO empty |
| over_o | output | 1 | Sticky overflow |
| under_o | output | 1 | Sticky underflow |
| dma_req_o | output | 1 | DMA request |
| irq_raw_o | output | 1 | Raw threshold interrupt |
| irq_o | output | 1 | Masked and forced interrupt |

## Verification
Directed sequences cover the corner cases:
- Filling the FIFO to four entries and pushing once more separates dropping the new sample from overwriting an old one.
- Draining it and then popping again shows that reads of an empty FIFO return 0.
- Pushing one value with shift and error keeping in each combination shows that bit 15 stays fixed while the value moves.
- Stepping the threshold across every level, including 0 and values above 4, checks the comparison edges.

A long random phase drives push, pop, enable, format, clear, mask and force inputs with skewed probabilities. This reaches simultaneous push and pop at every level, and clears that arrive in the same cycle as new events.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  typedef enum logic [0:0] {
    FLG_OVER  = 1'b0,
    FLG_UNDER = 1'b1
  } flag_e;
  localparam int unsigned N_FLAGS = 2;
endpackage

// File: rtl/sfifo_pack.sv
module sfifo_pack #(
  parameter int unsigned VAL_W  = 12,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic [VAL_W-1:0]  val_i,
  input  logic              err_i,
  input  logic              shift_i,
  input  logic              keep_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int unsigned SHAMT = VAL_W - BYTE_W;

  always_comb begin
    word_o = '0;
    word_o[VAL_W-1:0] = shift_i ? (val_i >> SHAMT) : val_i;
    // error bit position is fixed regardless of packing
    word_o[DATA_W-1]  = keep_i & err_i;
  end
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LVL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_word_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              ovf_evt_o,
  output logic              unf_evt_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0]  cnt_q;
  logic              push_ok, pop_ok;

  assign full_o    = (cnt_q == LVL_FULL);
  assign empty_o   = (cnt_q == '0);
  assign push_ok   = push_i & ~full_o;
  assign pop_ok    = pop_i & ~empty_o;
  assign ovf_evt_o = push_i & full_o;
  assign unf_evt_o = pop_i & empty_o;
  assign level_o   = cnt_q;
  assign head_o    = empty_o ? '0 : mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[g] <= '0;
      else if (push_ok && wr_ptr_q == PTR_W'(g)) mem_q[g] <= push_word_i;
    end
  end
endmodule

// File: rtl/sfifo_sticky.sv
module sfifo_sticky #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[g] <= 1'b0;
      else if (set_i[g]) flag_o[g] <= 1'b1;   // new event beats clear
      else if (clr_i[g]) flag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned VAL_W  = 12,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LVL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [VAL_W-1:0]  push_val_i,
  input  logic              push_err_i,
  input  logic              pop_i,
  input  logic              fifo_en_i,
  input  logic              shift_en_i,
  input  logic              err_keep_i,
  input  logic              req_en_i,
  input  logic [LVL_W-1:0]  thresh_i,
  input  logic              clr_over_i,
  input  logic              clr_under_i,
  input  logic              irq_en_i,
  input  logic              irq_force_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              over_o,
  output logic              under_o,
  output logic              dma_req_o,
  output logic              irq_raw_o,
  output logic              irq_o
);
  import sfifo_pkg::*;

  logic [DATA_W-1:0]  word;
  logic               ovf_evt, unf_evt;
  logic [N_FLAGS-1:0] flg_set, flg_clr, flg;

  sfifo_pack #(.VAL_W(VAL_W), .BYTE_W(BYTE_W), .DATA_W(DATA_W)) u_pack (
    .val_i   (push_val_i),
    .err_i   (push_err_i),
    .shift_i (shift_en_i),
    .keep_i  (err_keep_i),
    .word_o  (word)
  );

  sfifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i & fifo_en_i),
    .push_word_i (word),
    .pop_i       (pop_i),
    .head_o      (rd_data_o),
    .level_o     (level_o),
    .full_o      (full_o),
    .empty_o     (empty_o),
    .ovf_evt_o   (ovf_evt),
    .unf_evt_o   (unf_evt)
  );

  always_comb begin
    flg_set = '0;
    flg_clr = '0;
    flg_set[FLG_OVER]  = ovf_evt;
    flg_set[FLG_UNDER] = unf_evt;
    flg_clr[FLG_OVER]  = clr_over_i;
    flg_clr[FLG_UNDER] = clr_under_i;
  end

  sfifo_sticky #(.N(N_FLAGS)) u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flg_set),
    .clr_i  (flg_clr),
    .flag_o (flg)
  );

  assign over_o    = flg[FLG_OVER];
  assign under_o   = flg[FLG_UNDER];
  assign irq_raw_o = (level_o >= thresh_i);
  assign dma_req_o = irq_raw_o & req_en_i;
  assign irq_o     = (irq_raw_o & irq_en_i) | irq_force_i;
endmodule

// File: rtl/sample_fifo_chk.sv
module sample_fifo_chk #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LVL_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_i,
  input logic              pop_i,
  input logic              fifo_en_i,
  input logic              req_en_i,
  input logic              clr_over_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [LVL_W-1:0]  level_o,
  input logic              full_o,
  input logic              empty_o,
  input logic              over_o,
  input logic              under_o,
  input logic              dma_req_o
);
  // R2
  level_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LVL_W'(DEPTH) && !(full_o && empty_o));
  // R2
  no_push_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && !pop_i) |=> $stable(level_o));
  // R4
  empty_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> rd_data_o == '0);
  // R5
  push_pop_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && fifo_en_i && pop_i && !empty_o && !full_o) |=> $stable(level_o));
  // R6
  overflow_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && fifo_en_i && full_o) |=> over_o);
  // R7
  underflow_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o) |=> under_o);
  // R8
  over_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (over_o && !clr_over_i) |=> over_o);
  // R9
  req_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> req_en_i);
endmodule

bind sample_fifo sample_fifo_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .push_i     (push_i),
  .pop_i      (pop_i),
  .fifo_en_i  (fifo_en_i),
  .req_en_i   (req_en_i),
  .clr_over_i (clr_over_i),
  .rd_data_o  (rd_data_o),
  .level_o    (level_o),
  .full_o     (full_o),
  .empty_o    (empty_o),
  .over_o     (over_o),
  .under_o    (under_o),
  .dma_req_o  (dma_req_o)
);

// File: tb/sample_fifo_test.sv
`timescale 1ns/1ps
module sample_fifo_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_i = 0, push_err_i = 0, pop_i = 0, fifo_en_i = 0;
  logic [11:0] push_val_i = '0;
  logic        shift_en_i = 0, err_keep_i = 0, req_en_i = 0;
  logic [3:0]  thresh_i = '0;
  logic        clr_over_i = 0, clr_under_i = 0, irq_en_i = 0, irq_force_i = 0;
  logic [15:0] rd_data_o;
  logic [3:0]  level_o;
  logic        full_o, empty_o, over_o, under_o, dma_req_o, irq_raw_o, irq_o;

  int checks = 0, failures = 0;
  int cycles = 0;
  logic [15:0] q[$];
  logic m_over = 0, m_under = 0;

  always #2.5 clk_i = ~clk_i;

  sample_fifo uut (.*);

  function automatic logic [15:0] fmt(logic [11:0] v, logic e, logic sh, logic kp);
    logic [15:0] w = '0;
    w[11:0] = sh ? {4'b0, v[11:4]} : v;
    w[15]   = kp & e;
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare();
    logic [3:0]  lvl = 4'(q.size());
    logic        raw = (lvl >= thresh_i);
    chk("R4 rd_data", rd_data_o, (q.size() == 0) ? 0 : q[0]);
    chk("R2 level", level_o, lvl);
    chk("R2 full", full_o, lvl == 4);
    chk("R2 empty", empty_o, lvl == 0);
    chk("R8 over", over_o, m_over);
    chk("R8 under", under_o, m_under);
    chk("R9 dma_req", dma_req_o, raw & req_en_i);
    chk("R10 irq_raw", irq_raw_o, raw);
    chk("R10 irq", irq_o, (raw & irq_en_i) | irq_force_i);
  endtask

  // inputs already driven after a negedge; check, clock, update model
  task automatic step();
    logic ov, un, pok, wok;
    #1 compare();
    ov  = push_i & fifo_en_i & (q.size() == 4);
    wok = push_i & fifo_en_i & (q.size() < 4);
    un  = pop_i & (q.size() == 0);
    pok = pop_i & (q.size() > 0);
    @(posedge clk_i);
    if (pok) void'(q.pop_front());
    if (wok) q.push_back(fmt(push_val_i, push_err_i, shift_en_i, err_keep_i));
    m_over  = ov | (m_over & ~clr_over_i);
    m_under = un | (m_under & ~clr_under_i);
    @(negedge clk_i);
    cycles++;
  endtask

  task automatic idle();
    push_i = 0; pop_i = 0; clr_over_i = 0; clr_under_i = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 level", level_o, 0);
    chk("R1 empty", empty_o, 1);
    chk("R1 full", full_o, 0);
    chk("R1 flags", {over_o, under_o}, 0);
    chk("R1 rd_data", rd_data_o, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R2 push ignored while disabled
    push_i = 1; push_val_i = 12'h123; step();
    chk("R2 disabled push", level_o, 0);
    // R2 fill in order, then R6 overflow
    fifo_en_i = 1;
    for (int i = 0; i < 5; i++) begin
      push_val_i = 12'h100 + 12'(i * 17); step();
    end
    chk("R6 over set", over_o, 1);
    chk("R6 head kept", rd_data_o, 16'h100);
    // R6 push+pop while full: pop happens, push dropped
    clr_over_i = 1; push_val_i = 12'hFFF; pop_i = 1; step();
    chk("R6 over stays on clear+event", over_o, 1);
    chk("R6 level after full push+pop", level_o, 3);
    idle(); clr_over_i = 1; step();
    chk("R8 over cleared", over_o, 0);
    idle();
    // R4 drain, then R7 underflow with a same-cycle push
    pop_i = 1; repeat (3) step();
    push_i = 1; push_val_i = 12'h0AA; step();
    chk("R7 under set", under_o, 1);
    chk("R7 push kept", level_o, 1);
    idle(); pop_i = 1; step(); idle();
    // R3 all format combinations
    for (int f = 0; f < 4; f++) begin
      push_i = 1; push_val_i = 12'hABC; push_err_i = 1;
      shift_en_i = f[0]; err_keep_i = f[1]; step();
      idle();
      chk("R3 format", rd_data_o, fmt(12'hABC, 1'b1, f[0], f[1]));
      pop_i = 1; step(); idle();
    end
    // R9 R10 threshold sweep at each level
    req_en_i = 1; irq_en_i = 1;
    for (int l = 0; l < 5; l++) begin
      for (int t = 0; t < 6; t++) begin
        thresh_i = 4'(t); step();
      end
      push_i = 1; step(); idle();
    end
    irq_en_i = 0; irq_force_i = 1; thresh_i = 4'd15; step();
    irq_force_i = 0;

    // random phase
    for (int n = 0; n < 4000; n++) begin
      push_i      = ($urandom % 100) < 55;
      pop_i       = ($urandom % 100) < 45;
      push_val_i  = 12'($urandom);
      push_err_i  = $urandom % 2;
      fifo_en_i   = ($urandom % 100) < 90;
      shift_en_i  = $urandom % 2;
      err_keep_i  = $urandom % 2;
      req_en_i    = $urandom % 2;
      thresh_i    = 4'($urandom % 7);
      clr_over_i  = ($urandom % 100) < 15;
      clr_under_i = ($urandom % 100) < 15;
      irq_en_i    = $urandom % 2;
      irq_force_i = ($urandom % 100) < 10;
      step();
    end
    idle();
    step();
    finish_run();
  end
endmodule